// File: doc/BRIEF.md
# Mask-Driven Bit Scatter/Gather Unit

This block rearranges the bits of a W-bit source word under control of a W-bit mask. In scatter (deposit) mode, the low-order bits of the source are placed, one after another, into the bit positions where the mask holds a one. In gather (extract) mode, the source bits found under the mask's one positions are packed together into the low-order end of the result. Every result bit that no mask bit addresses reads as zero.

The unit is iterative. It walks the mask from its least significant set bit upward and retires one set bit per clock cycle. A trailing-zero counter locates the current lowest set bit. That bit is then cleared by AND-ing the mask with itself minus one, and a separate counter tracks the position on the packed side.

Operands arrive on a valid/ready input channel and results leave on a valid/ready output channel. A result that has not been taken stalls the unit: `out_valid` and `out_data` stay frozen and `in_ready` stays low until the consumer raises `out_ready`. In the cycle where a result is taken, a new operand set may be accepted.

Top module: `bitperm_unit`

## Requirements
- R1: When `in_op` = 0 (scatter), the set mask bit of rank k receives source bit k. Rank is counted from 0 at the least significant set bit.
- R2: When `in_op` = 1 (gather), result bit k receives the source bit that lies at the position of the mask's set bit of rank k.
- R3: Result bits that the walk does not write are zero, so a zero mask yields a zero result in both modes.
- R4: An all-ones mask returns the source unchanged in both modes.
- R5: After the cycle in which an operand set is accepted, `out_valid` first reads high popcount(mask)+1 cycles later.
- R6: A zero mask completes in the minimum time: `out_valid` is high on the second cycle after acceptance.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values and `in_ready` is low.
- R8: An operand set is taken only in a cycle where both `in_valid` and `in_ready` are high. Inputs offered while `in_ready` is low have no effect on the result in progress.
- R9: In a cycle where a result is handed off (`out_valid` and `out_ready` both high), `in_ready` is high, so a new operand set can be accepted in that same cycle.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| in_op | input | 1 | 0 = scatter, 1 = gather |
| in_src | input | W | Source word |
| in_mask | input | W | Selection mask |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | W | Permuted result |

## Verification
Two events can fall in the same cycle: handing off a finished result and accepting the next operand set. The bench provokes this by raising `out_ready` and `in_valid` together while a result is waiting. It then checks three things: `in_ready` is high in that cycle, the following cycle shows a busy unit with `out_valid` low, and the next result and latency match the reference model for the new operands. This confirms that the overlapped cycle neither drops nor duplicates an operation. Stalls with junk on the input channel are mixed in, to show that a blocked input cannot corrupt the result being held.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

  typedef enum logic {
    OP_SCATTER = 1'b0,
    OP_GATHER  = 1'b1
  } perm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_HOLD = 2'd2
  } perm_state_e;

endpackage

// File: rtl/bitperm_ctz.sv
// Trailing-zero count: index of the lowest set bit (0 when input is zero).
module bitperm_ctz #(
  parameter int W     = 32,
  localparam int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [POS_W-1:0] pos
);
  always_comb begin
    pos = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) pos = i[POS_W-1:0];
    end
  end
endmodule

// File: rtl/bitperm_step.sv
// One walk step: retire the lowest set mask bit and update the accumulator.
module bitperm_step
  import bitperm_pkg::*;
#(
  parameter int W     = 32,
  localparam int POS_W = $clog2(W)
) (
  input  perm_op_e         op,
  input  logic [W-1:0]     src,
  input  logic [W-1:0]     mask,
  input  logic [W-1:0]     acc,
  input  logic [POS_W-1:0] rank,
  output logic [W-1:0]     nxt_mask,
  output logic [W-1:0]     nxt_acc
);
  logic [POS_W-1:0] low_pos;
  logic [W-1:0]     low_bit;
  logic [W-1:0]     one_at_rank;

  bitperm_ctz #(.W(W)) u_ctz (.vec(mask), .pos(low_pos));

  always_comb begin
    low_bit     = mask & (~mask + {{(W-1){1'b0}}, 1'b1});
    one_at_rank = {{(W-1){1'b0}}, 1'b1} << rank;
    nxt_mask    = mask & (mask - {{(W-1){1'b0}}, 1'b1});
    if (op == OP_SCATTER) begin
      nxt_acc = src[rank] ? (acc | low_bit) : acc;
    end else begin
      nxt_acc = src[low_pos] ? (acc | one_at_rank) : acc;
    end
  end
endmodule

// File: rtl/bitperm_ctrl.sv
// Handshake sequencer: idle -> walk -> hold, with same-cycle hand-off.
module bitperm_ctrl
  import bitperm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic mask_empty,
  output logic in_ready,
  output logic out_valid,
  output logic take,
  output logic walk
);
  perm_state_e st_q, st_d;

  always_comb begin
    out_valid = (st_q == ST_HOLD);
    in_ready  = (st_q == ST_IDLE) || (out_valid && out_ready);
    take      = in_valid && in_ready;
    walk      = (st_q == ST_WALK) && !mask_empty;
    st_d      = st_q;
    unique case (st_q)
      ST_IDLE: if (take) st_d = ST_WALK;
      ST_WALK: if (mask_empty) st_d = ST_HOLD;
      ST_HOLD: begin
        if (take)           st_d = ST_WALK;
        else if (out_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import bitperm_pkg::*;
#(
  parameter int W     = 32,
  localparam int POS_W = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_op,
  input  logic [W-1:0] in_src,
  input  logic [W-1:0] in_mask,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  perm_op_e         op_q;
  logic [W-1:0]     src_q, mask_q, acc_q;
  logic [POS_W-1:0] rank_q;
  logic [W-1:0]     nxt_mask, nxt_acc;
  logic             take, walk;

  bitperm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .mask_empty(mask_q == '0), .in_ready(in_ready), .out_valid(out_valid),
    .take(take), .walk(walk)
  );

  bitperm_step #(.W(W)) u_step (
    .op(op_q), .src(src_q), .mask(mask_q), .acc(acc_q), .rank(rank_q),
    .nxt_mask(nxt_mask), .nxt_acc(nxt_acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_SCATTER;
      src_q  <= '0;
      mask_q <= '0;
      acc_q  <= '0;
      rank_q <= '0;
    end else if (take) begin
      op_q   <= perm_op_e'(in_op);
      src_q  <= in_src;
      mask_q <= in_mask;
      acc_q  <= '0;
      rank_q <= '0;
    end else if (walk) begin
      mask_q <= nxt_mask;
      acc_q  <= nxt_acc;
      rank_q <= rank_q + 1'b1;
    end
  end

  assign out_data = acc_q;
endmodule

// File: rtl/bitperm_unit_chk.sv
module bitperm_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_op,
  input logic [W-1:0] in_src,
  input logic [W-1:0] in_mask,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R9
  handoff_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |-> in_ready);
  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !out_valid && !in_ready);
  // R6
  empty_mask_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_mask == '0) |-> ##2 out_valid);
endmodule

bind bitperm_unit bitperm_unit_chk #(.W(W)) u_chk (.*);

// File: tb/sim_bitperm_unit.sv
module sim_bitperm_unit;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_op = 1'b0;
  logic [W-1:0] in_src = '0;
  logic [W-1:0] in_mask = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitperm_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src(in_src), .in_mask(in_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [W-1:0] ref_perm(logic op, logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = 0;
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin
        if (!op) r[i] = s[k];
        else     r[k] = s[i];
        k++;
      end
    end
    return r;
  endfunction

  function automatic int popc(logic [W-1:0] m);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(m[i]);
    return n;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at the negedge following the accepting edge.
  task automatic wait_result(logic op, logic [W-1:0] s, logic [W-1:0] m, bit junk);
    int cyc = 0;
    string tag;
    if (junk) begin
      in_valid = 1'b1; in_op = ~op; in_src = ~s; in_mask = ~m;
    end
    while (!out_valid && cyc < W + 6) begin
      @(negedge clk); cyc++;
    end
    check((m == '0) ? "R6" : "R5", cyc, popc(m) + 1);
    if (m == '0)            tag = "R3";
    else if (m == {W{1'b1}}) tag = "R4";
    else if (!op)           tag = "R1";
    else                    tag = "R2";
    if (junk) tag = "R8";
    check(tag, int'(out_data), int'(ref_perm(op, s, m)));
    if (junk) begin
      check("R7", int'(in_ready), 0);
      @(negedge clk);
      check("R7", int'(out_valid), 1);
      check("R7", int'(out_data), int'(ref_perm(op, s, m)));
      in_valid = 1'b0;
    end
  endtask

  task automatic start(logic op, logic [W-1:0] s, logic [W-1:0] m);
    in_valid = 1'b1; in_op = op; in_src = s; in_mask = m;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic release_out();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R9", int'(out_valid), 0);
    check("R10", int'(in_ready), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] srcs [4];
    logic [W-1:0] ps, pm;
    logic         pop;
    srcs[0] = 8'hA5; srcs[1] = 8'h3C; srcs[2] = 8'hFF; srcs[3] = 8'h00;
    repeat (3) @(negedge clk);
    check("R10", int'(out_valid), 0);
    check("R10", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", int'(in_ready), 1);

    // Sweep every mask with several sources, both modes.
    for (int m = 0; m < (1 << W); m++) begin
      for (int s = 0; s < 5; s++) begin
        for (int o = 0; o < 2; o++) begin
          logic [W-1:0] sv;
          sv = (s < 4) ? srcs[s] : W'($urandom);
          start(o[0], sv, W'(m));
          wait_result(o[0], sv, W'(m), (m % 37) == 5);
          release_out();
        end
      end
    end

    // All-ones mask, random sources.
    for (int i = 0; i < 32; i++) begin
      logic [W-1:0] sv;
      sv = W'($urandom);
      start(i[0], sv, {W{1'b1}});
      wait_result(i[0], sv, {W{1'b1}}, 1'b0);
      release_out();
    end

    // Back-to-back chain: hand-off and accept in the same cycle.
    ps = W'($urandom); pm = W'($urandom); pop = 1'b0;
    start(pop, ps, pm);
    wait_result(pop, ps, pm, 1'b0);
    for (int i = 0; i < 64; i++) begin
      logic [W-1:0] ns, nm;
      logic         no;
      ns = W'($urandom); nm = (i % 8 == 0) ? '0 : W'($urandom); no = i[1];
      out_ready = 1'b1; in_valid = 1'b1; in_op = no; in_src = ns; in_mask = nm;
      #1;
      check("R9", int'(in_ready), 1);
      @(negedge clk);
      out_ready = 1'b0; in_valid = 1'b0;
      check("R9", int'(out_valid), 0);
      wait_result(no, ns, nm, 1'b0);
    end
    release_out();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule